// File: doc/BRIEF.md
# Privileged Trap Entry and Return Controller

This block holds the processor's 32-bit flag word and three save registers, and it decides which control events may run in the current privilege mode. It accepts a decoded control request from the instruction stream, a synchronous exception with its vector, a maskable platform interrupt and a non-maskable hardware-error request. On a trap it copies the live instruction pointer, stack pointer and flags into the save registers. It then drops to supervisor mode with interrupts masked, fetches the handler address from a fixed descriptor table and hands that address to the fetch unit as the new instruction pointer.

Return from interrupt puts all three saved values back in a single cycle. Plain return restores only the instruction pointer. A privileged request made in user mode is not carried out. It becomes a general-protection trap instead. Writes to the upper half of the flag word are dropped outside supervisor mode.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the flag word is 0 (supervisor, interrupts disabled). `desc_req`, `ip_load`, `sp_load`, `prot_fault` and `priv_grant` are low.
- R2: An accepted trap with vector V does four things at the next clock edge. It copies `cur_ip`, `cur_sp` and the flag word into save registers 0, 1 and 2. It clears flag bits 16 (interrupt enable) and 17 (user mode). It raises `desc_req`. It sets `desc_addr` = TABLE_BASE + V*ENTRY_BYTES (defaults 0x800 and 4).
- R3: While `desc_req` is high, a cycle with `desc_valid` high ends the fetch. At the next edge `ip_load` pulses for one cycle with `ip_new` = `desc_data`, and `desc_req` falls.
- R4: In user mode (bit 17 = 1), op codes 1 (software interrupt), 3 (interrupt return), 5 (set IE), 6 (clear IE), 7 (halt) and 8 (TLB invalidate) do not execute. Each traps through vector 4, with `prot_fault` high for the cycle after acceptance.
- R5: Interrupt return (op 3) in supervisor mode loads the instruction pointer, stack pointer and flag word from save registers 0, 1 and 2 in one cycle. `ip_load` and `sp_load` are high together.
- R6: Plain return (op 4) pulses `ip_load` with `ip_new` = save register 0. `sp_load` stays low and the flags do not change.
- R7: In supervisor mode, op 5 sets flag bit 16 and op 6 clears it. No other bit changes.
- R8: Flag write (op 9) always replaces bits 15:0. It replaces bits 31:16 only in supervisor mode. Bits 31:19 always read as zero.
- R9: A platform interrupt (`irq_req`, vector `irq_vec`) is accepted only while bit 16 is set. `nmi_req` traps through vector 1 regardless of bit 16.
- R10: When several requests arrive in the same idle cycle, they are served in this order: `nmi_req`, then `exc_req`, then the control request, then `irq_req`.
- R11: System call (op 2) is allowed in either mode and traps through fixed vector 6 without `prot_fault`.
- R12: Halt (op 7) and TLB invalidate (op 8) in supervisor mode pulse `priv_grant` for one cycle and leave the flags unchanged.
- R13: While a descriptor fetch is outstanding, all new requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Control request present |
| op_code | input | 4 | Control request code (see R4–R12) |
| op_vec | input | 8 | Vector for software interrupt |
| op_wdata | input | 32 | Data for flag write |
| exc_req | input | 1 | Synchronous exception request |
| exc_vec | input | 8 | Exception vector |
| nmi_req | input | 1 | Non-maskable hardware-error request |
| irq_req | input | 1 | Maskable platform interrupt request |
| irq_vec | input | 8 | Platform interrupt vector |
| cur_ip | input | 32 | Current instruction pointer |
| cur_sp | input | 32 | Current stack pointer |
| desc_valid | input | 1 | Descriptor data valid |
| desc_data | input | 32 | Handler address read from table |
| flags | output | 32 | Live flag word |
| ip_load | output | 1 | Load `ip_new` into the instruction pointer |
| ip_new | output | 32 | New instruction pointer |
| sp_load | output | 1 | Load `sp_new` into the stack pointer |
| sp_new | output | 32 | New stack pointer |
| desc_req | output | 1 | Descriptor fetch outstanding |
| desc_addr | output | 32 | Descriptor entry address |
| prot_fault | output | 1 | Privilege violation trapped |
| priv_grant | output | 1 | Privileged halt/invalidate permitted |

## Verification
Every request is driven at a falling edge and accepted at the next rising edge. Its effect is read at the falling edge after that. Trap entry shows `desc_req`, the table address, the cleared mode bits and `prot_fault` there. Return, flag writes and grants also appear there. The handler address comes one edge after the bench drives `desc_valid`. A scoreboard queue holds every expected instruction-pointer load in order, and the monitor pops one entry only when `ip_load` is high. A load that was not expected, or one that never happens, is therefore reported. The responder can hold the fetch open for several cycles, so that requests made during that window can be checked to have no effect.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [3:0] {
        OP_NONE    = 4'd0,
        OP_SWINT   = 4'd1,
        OP_SYSCALL = 4'd2,
        OP_IRET    = 4'd3,
        OP_RET     = 4'd4,
        OP_SETIE   = 4'd5,
        OP_CLRIE   = 4'd6,
        OP_HALT    = 4'd7,
        OP_TLBINV  = 4'd8,
        OP_WRFLAGS = 4'd9
    } trap_op_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_TRAP,
        ACT_IRET,
        ACT_RET,
        ACT_SETIE,
        ACT_CLRIE,
        ACT_GRANT,
        ACT_WRFL
    } trap_act_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } trap_state_e;

    // flag bit positions the rest of the core decodes
    localparam int FL_IE = 16;
    localparam int FL_UM = 17;
    localparam int FL_PG = 18;

    // fixed vectors
    localparam int VEC_NMI_N     = 1;
    localparam int VEC_GPF_N     = 4;
    localparam int VEC_SYSCALL_N = 6;

endpackage

// File: rtl/trap_priv_check.sv
module trap_priv_check
    import trap_pkg::*;
(
    input  trap_op_e op,
    input  logic     user_mode,
    output logic     denied
);
    logic needs_sup;

    always_comb begin
        unique case (op)
            OP_SWINT, OP_IRET, OP_SETIE, OP_CLRIE, OP_HALT, OP_TLBINV: needs_sup = 1'b1;
            default:                                                   needs_sup = 1'b0;
        endcase
        denied = needs_sup & user_mode;
    end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             idle,
    input  logic             op_valid,
    input  trap_op_e         op,
    input  logic [VEC_W-1:0] op_vec,
    input  logic             denied,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic             nmi_req,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             ie,
    output trap_act_e        act,
    output logic [VEC_W-1:0] vec,
    output logic             fault
);
    always_comb begin
        act   = ACT_NONE;
        vec   = '0;
        fault = 1'b0;
        if (idle) begin
            if (nmi_req) begin
                act = ACT_TRAP;
                vec = VEC_W'(VEC_NMI_N);
            end else if (exc_req) begin
                act = ACT_TRAP;
                vec = exc_vec;
            end else if (op_valid) begin
                if (denied) begin
                    act   = ACT_TRAP;
                    vec   = VEC_W'(VEC_GPF_N);
                    fault = 1'b1;
                end else begin
                    unique case (op)
                        OP_SWINT:   begin act = ACT_TRAP; vec = op_vec; end
                        OP_SYSCALL: begin act = ACT_TRAP; vec = VEC_W'(VEC_SYSCALL_N); end
                        OP_IRET:    act = ACT_IRET;
                        OP_RET:     act = ACT_RET;
                        OP_SETIE:   act = ACT_SETIE;
                        OP_CLRIE:   act = ACT_CLRIE;
                        OP_HALT,
                        OP_TLBINV:  act = ACT_GRANT;
                        OP_WRFLAGS: act = ACT_WRFL;
                        default:    act = ACT_NONE;
                    endcase
                end
            end else if (irq_req && ie) begin
                act = ACT_TRAP;
                vec = irq_vec;
            end
        end
    end

    // R4: a privilege fault always resolves to a trap through the protection vector
    always_comb begin
        if (fault) begin
            assert_fault_gpf_R4: assert (act == ACT_TRAP && vec == VEC_W'(VEC_GPF_N));
        end
    end
endmodule

// File: rtl/trap_vec_addr.sv
module trap_vec_addr #(
    parameter int                ADDR_W      = 32,
    parameter int                VEC_W       = 8,
    parameter logic [ADDR_W-1:0] BASE        = '0,
    parameter int                ENTRY_BYTES = 4
) (
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] addr
);
    localparam int SH   = $clog2(ENTRY_BYTES);
    localparam bit POW2 = ((1 << SH) == ENTRY_BYTES);

    generate
        if (POW2) begin : g_shift
            assign addr = BASE + (ADDR_W'(vec) << SH);
        end else begin : g_mul
            assign addr = BASE + ADDR_W'(vec) * ADDR_W'(ENTRY_BYTES);
        end
    endgenerate
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              VEC_W       = 8,
    parameter logic [XLEN-1:0] TABLE_BASE  = 32'h0000_0800,
    parameter int              ENTRY_BYTES = 4,
    parameter int              PROT_HI     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic [VEC_W-1:0] op_vec,
    input  logic [XLEN-1:0]  op_wdata,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic             nmi_req,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic [XLEN-1:0]  cur_ip,
    input  logic [XLEN-1:0]  cur_sp,
    input  logic             desc_valid,
    input  logic [XLEN-1:0]  desc_data,
    output logic [XLEN-1:0]  flags,
    output logic             ip_load,
    output logic [XLEN-1:0]  ip_new,
    output logic             sp_load,
    output logic [XLEN-1:0]  sp_new,
    output logic             desc_req,
    output logic [XLEN-1:0]  desc_addr,
    output logic             prot_fault,
    output logic             priv_grant
);
    localparam logic [XLEN-1:0] LOW_MASK  = {{(XLEN-PROT_HI){1'b0}}, {PROT_HI{1'b1}}};
    localparam logic [XLEN-1:0] IMPL_MASK = LOW_MASK | (XLEN'(1) << FL_IE)
                                          | (XLEN'(1) << FL_UM) | (XLEN'(1) << FL_PG);
    localparam logic [XLEN-1:0] GPF_ADDR  = TABLE_BASE + XLEN'(VEC_GPF_N) * XLEN'(ENTRY_BYTES);

    typedef struct packed {
        trap_state_e     st;
        logic [XLEN-1:0] flags;
        logic [XLEN-1:0] save_ip;
        logic [XLEN-1:0] save_sp;
        logic [XLEN-1:0] save_fl;
        logic [XLEN-1:0] ip_new;
        logic [XLEN-1:0] sp_new;
        logic [XLEN-1:0] desc_addr;
        logic            ip_load;
        logic            sp_load;
        logic            fault;
        logic            grant;
    } regs_t;

    regs_t r_d, r_q;

    trap_op_e         op;
    logic             denied;
    trap_act_e        act;
    logic [VEC_W-1:0] act_vec;
    logic             act_fault;
    logic [XLEN-1:0]  vec_addr;

    assign op = trap_op_e'(op_code);

    trap_priv_check u_priv (
        .op        (op),
        .user_mode (r_q.flags[FL_UM]),
        .denied    (denied)
    );

    trap_arbiter #(.VEC_W(VEC_W)) u_arb (
        .idle     (r_q.st == ST_IDLE),
        .op_valid (op_valid),
        .op       (op),
        .op_vec   (op_vec),
        .denied   (denied),
        .exc_req  (exc_req),
        .exc_vec  (exc_vec),
        .nmi_req  (nmi_req),
        .irq_req  (irq_req),
        .irq_vec  (irq_vec),
        .ie       (r_q.flags[FL_IE]),
        .act      (act),
        .vec      (act_vec),
        .fault    (act_fault)
    );

    trap_vec_addr #(
        .ADDR_W      (XLEN),
        .VEC_W       (VEC_W),
        .BASE        (TABLE_BASE),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_addr (
        .vec  (act_vec),
        .addr (vec_addr)
    );

    always_comb begin
        r_d         = r_q;
        r_d.ip_load = 1'b0;
        r_d.sp_load = 1'b0;
        r_d.fault   = 1'b0;
        r_d.grant   = 1'b0;
        if (r_q.st == ST_IDLE) begin
            case (act)
                ACT_TRAP: begin
                    r_d.save_ip      = cur_ip;
                    r_d.save_sp      = cur_sp;
                    r_d.save_fl      = r_q.flags;
                    r_d.flags[FL_IE] = 1'b0;
                    r_d.flags[FL_UM] = 1'b0;
                    r_d.desc_addr    = vec_addr;
                    r_d.fault        = act_fault;
                    r_d.st           = ST_FETCH;
                end
                ACT_IRET: begin
                    r_d.ip_new  = r_q.save_ip;
                    r_d.ip_load = 1'b1;
                    r_d.sp_new  = r_q.save_sp;
                    r_d.sp_load = 1'b1;
                    r_d.flags   = r_q.save_fl;
                end
                ACT_RET: begin
                    r_d.ip_new  = r_q.save_ip;
                    r_d.ip_load = 1'b1;
                end
                ACT_SETIE: r_d.flags[FL_IE] = 1'b1;
                ACT_CLRIE: r_d.flags[FL_IE] = 1'b0;
                ACT_GRANT: r_d.grant = 1'b1;
                ACT_WRFL: begin
                    if (r_q.flags[FL_UM]) begin
                        r_d.flags = (r_q.flags & ~LOW_MASK) | (op_wdata & LOW_MASK);
                    end else begin
                        r_d.flags = op_wdata & IMPL_MASK;
                    end
                end
                default: ;
            endcase
        end else begin
            if (desc_valid) begin
                r_d.ip_new  = desc_data;
                r_d.ip_load = 1'b1;
                r_d.st      = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign flags      = r_q.flags;
    assign ip_load    = r_q.ip_load;
    assign ip_new     = r_q.ip_new;
    assign sp_load    = r_q.sp_load;
    assign sp_new     = r_q.sp_new;
    assign desc_req   = (r_q.st == ST_FETCH);
    assign desc_addr  = r_q.desc_addr;
    assign prot_fault = r_q.fault;
    assign priv_grant = r_q.grant;

    // R2: handler entry always runs in supervisor mode with interrupts masked
    assert_entry_supervisor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_req) |-> (!flags[FL_UM] && !flags[FL_IE]));

    // R3: descriptor response ends the fetch and loads the pointer next cycle
    assert_fetch_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_req && desc_valid) |=> (ip_load && !desc_req));

    // R4: a protection fault points at the protection entry of the table
    assert_fault_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> (desc_req && desc_addr == GPF_ADDR));

    // R5: return restores the saved flag word together with both pointers
    assert_iret_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && act == ACT_IRET) |=>
            (r_q.flags == $past(r_q.save_fl) && ip_load && sp_load));

    // R8: upper flag half holds while in user mode unless a trap is taken
    assert_user_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flags[FL_UM] && act != ACT_TRAP && act != ACT_IRET) |=>
            (r_q.flags[XLEN-1:PROT_HI] == $past(r_q.flags[XLEN-1:PROT_HI])));

    // R9: a masked platform interrupt alone starts no fetch
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && irq_req && !r_q.flags[FL_IE] && !nmi_req && !exc_req && !op_valid)
            |=> !desc_req);
endmodule

// File: tb/trap_ctrl_tb_top.sv
module trap_ctrl_tb_top;
    localparam logic [31:0] BASE = 32'h0000_0800;
    localparam logic [31:0] KEY  = 32'h5A00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [7:0]  op_vec = '0;
    logic [31:0] op_wdata = '0;
    logic        exc_req = 1'b0;
    logic [7:0]  exc_vec = '0;
    logic        nmi_req = 1'b0;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_vec = '0;
    logic [31:0] cur_ip = 32'h0000_1000;
    logic [31:0] cur_sp = 32'h0000_8000;
    logic        desc_valid = 1'b0;
    logic [31:0] desc_data = '0;
    logic [31:0] flags, ip_new, sp_new, desc_addr;
    logic        ip_load, sp_load, desc_req, prot_fault, priv_grant;

    trap_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_vec(op_vec), .op_wdata(op_wdata), .exc_req(exc_req), .exc_vec(exc_vec),
        .nmi_req(nmi_req), .irq_req(irq_req), .irq_vec(irq_vec), .cur_ip(cur_ip),
        .cur_sp(cur_sp), .desc_valid(desc_valid), .desc_data(desc_data), .flags(flags),
        .ip_load(ip_load), .ip_new(ip_new), .sp_load(sp_load), .sp_new(sp_new),
        .desc_req(desc_req), .desc_addr(desc_addr), .prot_fault(prot_fault),
        .priv_grant(priv_grant)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [31:0] ip;
        logic        spl;
        logic [31:0] sp;
        string       tag;
    } exp_t;

    exp_t        q_ip[$];
    logic [31:0] q_addr[$];
    int          n_chk = 0;
    int          n_err = 0;
    int          hold_req = 0;
    int          wait_cnt = 0;
    logic [31:0] m_flags = '0;
    logic [31:0] sv_ip = '0, sv_sp = '0, sv_fl = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // descriptor table responder: checks the address and returns a handler pointer
    always @(negedge clk) begin
        if (desc_valid) begin
            desc_valid <= 1'b0;
        end else if (desc_req) begin
            if (wait_cnt < hold_req) begin
                wait_cnt <= wait_cnt + 1;
            end else begin
                wait_cnt <= 0;
                if (q_addr.size() == 0) begin
                    chk("R2 unexpected desc_req", desc_addr, 32'hFFFF_FFFF);
                end else begin
                    chk("R2 desc_addr", desc_addr, q_addr.pop_front());
                end
                desc_valid <= 1'b1;
                desc_data  <= desc_addr ^ KEY;
                q_ip.push_back('{desc_addr ^ KEY, 1'b0, 32'h0, "R3"});
            end
        end
    end

    // monitor: every pointer load must match the next scoreboard item
    always @(negedge clk) begin
        if (rst_n && ip_load) begin
            if (q_ip.size() == 0) begin
                chk("R3 unexpected ip_load", ip_new, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = q_ip.pop_front();
                chk({e.tag, " ip_new"}, ip_new, e.ip);
                chk({e.tag, " sp_load"}, {31'b0, sp_load}, {31'b0, e.spl});
                if (e.spl) chk({e.tag, " sp_new"}, sp_new, e.sp);
            end
        end
    end

    task automatic pulse(input logic [3:0] op, input logic [7:0] ov = 0, input logic [31:0] wd = 0,
                         input bit ex = 0, input logic [7:0] exv = 0, input bit iq = 0,
                         input logic [7:0] iv = 0, input bit nm = 0);
        @(negedge clk);
        op_valid = (op != 4'd0); op_code = op; op_vec = ov; op_wdata = wd;
        exc_req = ex; exc_vec = exv; irq_req = iq; irq_vec = iv; nmi_req = nm;
        @(negedge clk);
        op_valid = 1'b0; op_code = '0; exc_req = 1'b0; irq_req = 1'b0; nmi_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && desc_req; i++) @(negedge clk);
    endtask

    task automatic prep_entry(input int v);
        sv_ip = cur_ip; sv_sp = cur_sp; sv_fl = m_flags;
        m_flags[16] = 1'b0; m_flags[17] = 1'b0;
        q_addr.push_back(BASE + 32'(v) * 32'd4);
    endtask

    task automatic enter(input string req, input int v, input bit f, input logic [3:0] op,
                         input logic [7:0] ov = 0, input bit ex = 0, input logic [7:0] exv = 0,
                         input bit iq = 0, input logic [7:0] iv = 0, input bit nm = 0);
        prep_entry(v);
        pulse(op, ov, 32'h0, ex, exv, iq, iv, nm);
        chk({req, " desc_req"}, {31'b0, desc_req}, 32'd1);
        chk({req, " flags after entry"}, flags, m_flags);
        chk({req, " prot_fault"}, {31'b0, prot_fault}, {31'b0, f});
        wait_idle();
        cur_ip = cur_ip + 32'h40;
        cur_sp = cur_sp - 32'h10;
    endtask

    task automatic do_iret(input string req);
        q_ip.push_back('{sv_ip, 1'b1, sv_sp, req});
        m_flags = sv_fl;
        pulse(4'd3);
        chk({req, " flags restored"}, flags, m_flags);
    endtask

    task automatic do_flags_op(input string req, input logic [3:0] op, input logic [31:0] wd,
                               input logic [31:0] exp);
        m_flags = exp;
        pulse(op, 8'h0, wd);
        chk(req, flags, m_flags);
        chk({req, " no fault"}, {31'b0, desc_req}, 32'd0);
    endtask

    task automatic run();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags", flags, 32'h0);
        chk("R1 desc_req", {31'b0, desc_req}, 32'd0);
        chk("R1 ip_load", {31'b0, ip_load}, 32'd0);
        chk("R1 prot_fault", {31'b0, prot_fault | priv_grant | sp_load}, 32'd0);

        // R8: supervisor write, reserved bits 31:19 dropped
        do_flags_op("R8 sup write", 4'd9, 32'hFFF9_1234, 32'h0001_1234);
        // R2 R3: software interrupt in supervisor mode
        enter("R2 swint 40", 40, 1'b0, 4'd1, 8'd40);
        do_iret("R5");
        // R6: plain return restores only the instruction pointer
        q_ip.push_back('{sv_ip, 1'b0, 32'h0, "R6"});
        pulse(4'd4);
        chk("R6 flags unchanged", flags, m_flags);
        // enter user mode with interrupts and paging on
        do_flags_op("R8 sup write upper", 4'd9, 32'h0007_00FF, 32'h0007_00FF);
        do_flags_op("R8 user write", 4'd9, 32'h0000_ABCD, 32'h0007_ABCD);
        // R4: privileged ops in user mode trap through vector 4
        enter("R4 user clrie", 4, 1'b1, 4'd6);
        chk("R4 saved IE kept", flags & 32'h0001_0000, 32'h0);
        do_iret("R4 ret");
        chk("R4 IE still set", flags & 32'h0001_0000, 32'h0001_0000);
        prep_entry(4);
        pulse(4'd7);
        chk("R4 user halt no grant", {31'b0, priv_grant}, 32'd0);
        chk("R4 user halt fault", {31'b0, prot_fault}, 32'd1);
        wait_idle();
        do_iret("R4 ret2");
        enter("R4 user iret", 4, 1'b1, 4'd3);
        do_iret("R4 ret3");
        // R11: system call from user mode
        enter("R11 syscall", 6, 1'b0, 4'd2);
        // R9: masked platform interrupt is ignored, hardware error is not
        for (int i = 0; i < 3; i++) begin
            pulse(4'd0, 0, 0, 0, 0, 1'b1, 8'd50);
            chk("R9 masked irq", {31'b0, desc_req}, 32'd0);
        end
        chk("R9 flags after masked irq", flags, m_flags);
        enter("R9 nmi", 1, 1'b0, 4'd0, 0, 0, 0, 0, 0, 1'b1);
        do_iret("R9 nmi ret");
        // R7: interrupt flag set/clear in supervisor
        do_flags_op("R7 setie", 4'd5, 32'h0, m_flags | 32'h0001_0000);
        enter("R9 irq 50", 50, 1'b0, 4'd0, 0, 0, 0, 1'b1, 8'd50);
        do_iret("R9 irq ret");
        do_flags_op("R7 clrie", 4'd6, 32'h0, m_flags & ~32'h0001_0000);
        // R12: grants in supervisor
        pulse(4'd7);
        chk("R12 halt grant", {31'b0, priv_grant}, 32'd1);
        chk("R12 halt flags", flags, m_flags);
        pulse(4'd8);
        chk("R12 tlbinv grant", {31'b0, priv_grant}, 32'd1);
        // R10: priority among simultaneous requests
        do_flags_op("R10 setie", 4'd5, 32'h0, m_flags | 32'h0001_0000);
        enter("R10 nmi wins", 1, 1'b0, 4'd1, 8'd20, 1'b1, 8'd3, 1'b1, 8'd60, 1'b1);
        do_iret("R10 ret1");
        enter("R10 exc wins", 3, 1'b0, 4'd1, 8'd20, 1'b1, 8'd3, 1'b1, 8'd60);
        do_iret("R10 ret2");
        enter("R10 op over irq", 20, 1'b0, 4'd1, 8'd20, 0, 0, 1'b1, 8'd60);
        do_iret("R10 ret3");
        // R13: requests during an outstanding fetch have no effect
        hold_req = 4;
        prep_entry(9);
        pulse(4'd1, 8'd9);
        pulse(4'd9, 8'd0, 32'h0000_0000);
        chk("R13 write ignored", flags, m_flags);
        pulse(4'd5);
        chk("R13 setie ignored", flags, m_flags);
        chk("R13 still fetching", {31'b0, desc_req}, 32'd1);
        wait_idle();
        hold_req = 0;
        do_iret("R13 ret");
        repeat (3) @(negedge clk);
        chk("R3 scoreboard drained", 32'(q_ip.size() + q_addr.size()), 32'd0);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule